// File: doc/BRIEF.md
# Prefix-Decoded Serial Configuration Register File

This block is a write-only serial slave. It takes 8-bit programming words from a host over a chip-select, clock and data line triple. Each word lands in one of five configuration registers inside a signal-conditioning front end. The top of each word holds an address prefix, either two or three bits long. The prefix picks the target register, and the bits that remain are that register's new value. The registers drive:

- the band-pass centre-frequency code
- the gain code
- the integrator time-constant code
- the channel select and the diagnostic mode
- the prescaler code
- the enable of the serial output driver

All three serial inputs are brought into the system clock domain through synchronizers and are oversampled there. A word is committed only when chip select returns high after exactly eight falling clock edges. The integrate/hold level gates every commit: words are accepted only while it is low, which is hold mode. A host therefore programs the block between integration windows, and stray or truncated transfers cannot disturb the settings.

Top module: `cfgspi_regfile`

## Requirements
- R1: After a synchronous active-low reset, every configuration output is zero and `so_drive_en` is 0, so the serial output is high impedance.
- R2: While `spi_cs_n` is low, `spi_mosi` is sampled on each falling edge of `spi_sck`, and the first bit received is bit 7 of the word (most significant bit first).
- R3: A committed word with bits 7:6 equal to 2'b00 loads bits 5:0 into `freq_code`.
- R4: A committed word with bits 7:6 equal to 2'b10 loads bits 5:0 into `gain_code`.
- R5: A committed word with bits 7:5 equal to 3'b110 loads bits 4:0 into `itc_code`.
- R6: A committed word with bits 7:5 equal to 3'b111 loads bit 0 into `chan_sel` and bits 4:1 into `diag_mode`.
- R7: A committed word with bits 7:6 equal to 2'b01 loads bits 4:1 into `presc_code`, ignores bit 5, and sets `so_drive_en` to the inverse of bit 0: a 0 there drives the output, a 1 makes it high impedance.
- R8: A committed word changes only the register its prefix addresses; all other outputs keep their values.
- R9: When chip select rises after any number of falling clock edges other than eight, including zero, seven and nine, the word is discarded and no output changes.
- R10: A word that completes while `integ_mode` is high is ignored and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial bit clock; data is taken on its falling edge |
| spi_mosi | input | 1 | Serial data in, most significant bit first |
| integ_mode | input | 1 | High while integrating; writes are accepted only while it is low |
| freq_code | output | 6 | Band-pass centre-frequency code |
| gain_code | output | 6 | Gain code |
| itc_code | output | 5 | Integrator time-constant code |
| chan_sel | output | 1 | Input channel select |
| diag_mode | output | 4 | Diagnostic mode field |
| presc_code | output | 4 | Prescaler code |
| so_drive_en | output | 1 | 1 drives the serial output pin, 0 leaves it high impedance |

## Verification
Each prefix class is sent in turn, with value bits that are asymmetric under bit reversal, so that a reversed shift order or a wrong field slice gives a visibly different code. The prescaler word is sent once with the unused bit 5 set and the drive bit set, and once with both clear. This separates the bit 5 that must be ignored from the drive-enable inversion. After every frame the full set of outputs is compared, which exposes any write that reaches a neighbouring register. Frames of zero, seven and nine bits, and full frames sent while integrating, must leave every output unchanged; a mid-run reset must return all outputs to zero.

// File: rtl/cfgspi_pkg.sv
// Package: shared widths and the configuration record for the
// prefix-decoded serial register file.
// Assumes: 8-bit words, with a two- or three-bit prefix at the top.
package cfgspi_pkg;

    localparam int WORD_W  = 8;
    localparam int FREQ_W  = 6;
    localparam int GAIN_W  = 6;
    localparam int ITC_W   = 5;
    localparam int DIAG_W  = 4;
    localparam int PRESC_W = 4;
    localparam int CNT_W   = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    // One-hot index of each write target
    typedef enum logic [2:0] {
        TGT_FREQ  = 3'd0,
        TGT_GAIN  = 3'd1,
        TGT_ITC   = 3'd2,
        TGT_TEST  = 3'd3,
        TGT_PRESC = 3'd4
    } tgt_e;

    localparam int NUM_TGT = 5;

    // Complete configuration state
    typedef struct packed {
        logic [FREQ_W-1:0]  freq;
        logic [GAIN_W-1:0]  gain;
        logic [ITC_W-1:0]   itc;
        logic               chan;
        logic [DIAG_W-1:0]  diag;
        logic [PRESC_W-1:0] presc;
        logic               so_oe;
    } cfg_t;

endpackage

// File: rtl/cfgspi_sync.sv
// Module: cfgspi_sync
// Brings a vector of asynchronous levels into the clk domain through a
// chain of STAGES flops.
// Assumes: every bit is a slow level, relative to clk, that may be
// resynchronized on its own.
module cfgspi_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/cfgspi_shifter.sv
// Module: cfgspi_shifter
// Assembles serial bits, most significant first, on the falling edges
// of the synchronized bit clock while chip select is active. On the
// rising edge of chip select it raises word_valid for one cycle, but
// only when exactly WORD_W bits were received.
// Assumes: inputs have already been synchronized to clk, and the bit
// clock runs slower than clk/4.
module cfgspi_shifter
    import cfgspi_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n_q,
    input  logic         sck_q,
    input  logic         mosi_q,
    output logic         word_valid,
    output logic [W-1:0] word
);

    localparam logic [CW-1:0] CNT_SAT  = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_FULL = CW'(W);

    logic          sck_d, cs_n_d;
    logic          sck_fall, cs_rise, cs_act;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  shreg;

    // Keep the previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            cs_n_d <= 1'b1;
        end else begin
            sck_d  <= sck_q;
            cs_n_d <= cs_n_q;
        end
    end

    assign sck_fall = sck_d & ~sck_q;
    assign cs_rise  = cs_n_q & ~cs_n_d;
    assign cs_act   = ~cs_n_q;

    // Shift in data and count the bits of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
        end else if (sck_fall) begin
            shreg   <= {shreg[W-2:0], mosi_q};
            bit_cnt <= (bit_cnt == CNT_SAT) ? CNT_SAT : bit_cnt + 1'b1;
        end
    end

    assign word_valid = cs_rise && (bit_cnt == CNT_FULL);
    assign word       = shreg;

    // R2
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && sck_fall && bit_cnt != CNT_SAT) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

endmodule

// File: rtl/cfgspi_regs.sv
// Module: cfgspi_regs
// Decodes the address prefix of a completed word and loads its value
// field into the one addressed configuration register.
// Assumes: word_valid is a single-cycle pulse, and hold_ok is the
// synchronized inverse of the integrate level.
module cfgspi_regs
    import cfgspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              hold_ok,
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg
);

    logic [NUM_TGT-1:0] we;
    logic               commit;

    assign commit = word_valid & hold_ok;

    // Map the two- or three-bit prefix onto a one-hot write enable
    always_comb begin
        we = '0;
        if (commit) begin
            unique case (word[7:6])
                2'b00: we[TGT_FREQ]  = 1'b1;
                2'b10: we[TGT_GAIN]  = 1'b1;
                2'b01: we[TGT_PRESC] = 1'b1;
                2'b11: begin
                    if (word[5]) we[TGT_TEST] = 1'b1;
                    else         we[TGT_ITC]  = 1'b1;
                end
                default: we = '0;
            endcase
        end
    end

    // Load the addressed register from the value field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (we[TGT_FREQ])  cfg.freq  <= word[FREQ_W-1:0];
            if (we[TGT_GAIN])  cfg.gain  <= word[GAIN_W-1:0];
            if (we[TGT_ITC])   cfg.itc   <= word[ITC_W-1:0];
            if (we[TGT_TEST]) begin
                cfg.chan <= word[0];
                cfg.diag <= word[DIAG_W:1];
            end
            if (we[TGT_PRESC]) begin
                cfg.presc <= word[PRESC_W:1];
                cfg.so_oe <= ~word[0];
            end
        end
    end

    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

endmodule

// File: rtl/cfgspi_regfile.sv
// Module: cfgspi_regfile (top)
// Write-only serial slave that routes each 8-bit word to one of five
// configuration registers by its prefix. Writes are taken only in hold
// mode (integ_mode low).
// Assumes: clk runs at least four times faster than spi_sck, and
// integ_mode is steady around the end of each frame.
module cfgspi_regfile
    import cfgspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_cs_n,
    input  logic               spi_sck,
    input  logic               spi_mosi,
    input  logic               integ_mode,
    output logic [FREQ_W-1:0]  freq_code,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [ITC_W-1:0]   itc_code,
    output logic               chan_sel,
    output logic [DIAG_W-1:0]  diag_mode,
    output logic [PRESC_W-1:0] presc_code,
    output logic               so_drive_en
);

    logic [3:0]        sync_q;
    logic              cs_n_q, sck_q, mosi_q, integ_q;
    logic              word_valid;
    logic [WORD_W-1:0] word;
    cfg_t              cfg;

    cfgspi_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1000)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sck, spi_mosi, integ_mode}),
        .q     (sync_q)
    );

    assign {cs_n_q, sck_q, mosi_q, integ_q} = sync_q;

    cfgspi_shifter i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_q     (cs_n_q),
        .sck_q      (sck_q),
        .mosi_q     (mosi_q),
        .word_valid (word_valid),
        .word       (word)
    );

    cfgspi_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .hold_ok    (~integ_q),
        .word       (word),
        .cfg        (cfg)
    );

    assign freq_code   = cfg.freq;
    assign gain_code   = cfg.gain;
    assign itc_code    = cfg.itc;
    assign chan_sel    = cfg.chan;
    assign diag_mode   = cfg.diag;
    assign presc_code  = cfg.presc;
    assign so_drive_en = cfg.so_oe;

    // R10
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        integ_q |=> $stable(cfg));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(cfg));

    // R4
    gain_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !integ_q && word[7:6] == 2'b10)
        |=> (cfg.gain == $past(word[5:0]) && cfg.freq == $past(cfg.freq)));

endmodule

// File: tb/test_cfgspi_regfile.sv
module test_cfgspi_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       integ_mode = 1'b0;
    logic [5:0] freq_code, gain_code;
    logic [4:0] itc_code;
    logic       chan_sel;
    logic [3:0] diag_mode, presc_code;
    logic       so_drive_en;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    cfgspi_regfile i_cfgspi_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .integ_mode  (integ_mode),
        .freq_code   (freq_code),
        .gain_code   (gain_code),
        .itc_code    (itc_code),
        .chan_sel    (chan_sel),
        .diag_mode   (diag_mode),
        .presc_code  (presc_code),
        .so_drive_en (so_drive_en)
    );

    // Layout of the state: freq[26:21] gain[20:15] itc[14:10] chan[9] diag[8:5] presc[4:1] oe[0]
    logic [26:0] model = '0;

    function automatic logic [26:0] actual();
        return {freq_code, gain_code, itc_code, chan_sel, diag_mode, presc_code, so_drive_en};
    endfunction

    // Expected state from the requirements
    function automatic logic [26:0] apply(logic [26:0] s, logic [7:0] w);
        logic [26:0] r = s;
        if (w[7:6] == 2'b00)      r[26:21] = w[5:0];
        else if (w[7:6] == 2'b10) r[20:15] = w[5:0];
        else if (w[7:5] == 3'b110) r[14:10] = w[4:0];
        else if (w[7:5] == 3'b111) begin r[9] = w[0]; r[8:5] = w[4:1]; end
        else begin r[4:1] = w[4:1]; r[0] = ~w[0]; end
        return r;
    endfunction

    function automatic string req_name(int id);
        case (id)
            2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";
            8: return "R8";  9: return "R9";  10: return "R10";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string req, logic [26:0] exp);
        logic [26:0] act = actual();
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %07h expected %07h", req, act, exp);
        end
    endtask

    // Send nbits bits of w, most significant first; bits past eight are zero
    task automatic send_frame(logic [7:0] w, int nbits);
        spi_cs_n = 1'b0;
        repeat (4) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 8) ? w[7-i] : 1'b0;
            spi_sck  = 1'b1;
            repeat (4) @(posedge clk);
            spi_sck  = 1'b0;
            repeat (4) @(posedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
    endtask

    // {integ, nbits[3:0], word[7:0], req[3:0]}
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 4'd8, 8'b00_001010, 4'd3},
        {1'b0, 4'd8, 8'b10_010100, 4'd4},
        {1'b0, 4'd8, 8'b110_00011, 4'd5},
        {1'b0, 4'd8, 8'b111_10101, 4'd6},
        {1'b0, 4'd8, 8'b01_1_0110_0, 4'd7},
        {1'b0, 4'd8, 8'b01_0_1001_1, 4'd7},
        {1'b0, 4'd8, 8'b00_110001, 4'd8},
        {1'b0, 4'd8, 8'b10_111111, 4'd8},
        {1'b0, 4'd7, 8'b00_000111, 4'd9},
        {1'b0, 4'd9, 8'b10_000001, 4'd9},
        {1'b1, 4'd8, 8'b110_11111, 4'd10},
        {1'b1, 4'd8, 8'b111_00000, 4'd10},
        {1'b0, 4'd8, 8'b110_10110, 4'd5},
        {1'b0, 4'd8, 8'b00_101101, 4'd2}
    };

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", '0);

        for (int v = 0; v < NV; v++) begin
            logic       ig = VEC[v][16];
            int         nb = int'(VEC[v][15:12]);
            logic [7:0] w  = VEC[v][11:4];
            integ_mode = ig;
            repeat (6) @(posedge clk);
            send_frame(w, nb);
            if (nb == 8 && !ig) model = apply(model, w);
            check(req_name(int'(VEC[v][3:0])), model);
            integ_mode = 1'b0;
        end

        // R9: chip-select pulse with no bits
        send_frame(8'h00, 0);
        check("R9", model);

        // R7: prescaler word re-enables the driver, bit 5 ignored
        send_frame(8'b01_1_1111_0, 8);
        model = apply(model, 8'b01_1_1111_0);
        check("R7", model);

        // R1: reset mid-run clears everything
        @(posedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        model = '0;
        repeat (4) @(posedge clk);

        // R6: test word after reset
        send_frame(8'b111_01110, 8);
        model = apply(model, 8'b111_01110);
        check("R6", model);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule